// File: doc/BRIEF.md
# Battery Protection Fault Controller

This block is the digital supervisor for the two series switches of a single rechargeable lithium-ion cell. One switch carries charge current and the other carries discharge current. Comparator results arrive as synchronous one-bit inputs: cell too high, cell below the charge-enable level, cell too low, cell severely depleted, switch drop too high, pack terminal recovered, charger present and device too hot. The block qualifies each condition with its own delay counter and latches the resulting fault. It gates the two switch enables, the load-test current enable and the recovery-charge enable.

The block has two power modes. In the active mode it monitors all conditions. In the sleep mode it holds both switches off and monitors nothing. A confirmed under-voltage puts the block to sleep. A low level on the wake pin or a detected charger wakes it, provided the cell is not severely depleted.

A host write port updates the sticky fault flags and the two switch permissions. Two read-only bytes show the flags and the live switch states. All delays are parameters counted in clock ticks.

Top module: `batt_guard`

## Requirements
- R1: After reset the block sleeps, all four enables are 0, `status_prot` reads 8'h53 and `status_feat` reads 8'h80.
- R2: While asleep, the block becomes active on the next edge at which `wake_n` is 0 or `chg_det` is 1, as long as `depl_cmp` is 0. While `depl_cmp` is 1 it stays asleep. The wake edge sets the charge and discharge permissions (`status_prot` bits 1 and 0) to 1.
- R3: While active, `ov_cmp` sampled high on OV_TICKS consecutive edges clears `chg_en` at the last of those edges and sets the over-voltage flag (`status_prot` bit 7). `dchg_en` stays on. A low sample restarts the count from zero.
- R4: An over-voltage trip releases at the first edge where `below_ce` or `oc_cmp` is high, unless another fault still blocks charge.
- R5: While active, `uv_cmp` high on UV_TICKS consecutive edges clears both enables, sets the under-voltage flag (bit 6) and enters sleep.
- R6: While active, `oc_cmp` high on OC_TICKS consecutive edges, or `depl_cmp` high on SC_TICKS consecutive edges, clears both enables and sets the current-fault flag (bit 4). It also raises `test_en`. This state lasts until an edge with `pack_ok` high.
- R7: `rcv_en` is 1 only while a current fault that began as a depletion trip is pending and `depl_cmp` is 0. An over-current trip never raises it.
- R8: `ot_cmp` high clears both enables in the same cycle and sets the OT flag (`status_feat` bit 0) at the next edge. Both enables return only after `ot_cmp` is low and the host has written OT to 0. A host write of 1 to OT forces both enables off.
- R9: A host write to `status_prot` with bit 1 = 0 forces `chg_en` off, and with bit 0 = 0 forces `dchg_en` off.
- R10: On the wake edge the over-voltage delay is zero. If `ov_cmp` is 1 at that edge, `chg_en` stays off and the over-voltage flag is set.
- R11: The over-voltage, under-voltage and current-fault flags change to 0 only through a host write of 0. The wake flag (`status_feat` bit 7) clears at any edge with `wake_n` low, changes to 1 only through a host write, and is 1 after reset. A hardware set wins over a host write in the same cycle.
- R12: `status_prot` is {OV flag, UV flag, 0, current-fault flag, `chg_en`, `dchg_en`, charge permission, discharge permission}, MSB first. A write with `wr_sel`=0 takes bits 7, 6, 4, 1 and 0. A write with `wr_sel`=1 takes bit 7 (wake flag) and bit 0 (OT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_cmp | input | 1 | Cell above over-voltage threshold |
| below_ce | input | 1 | Cell below charge-enable threshold |
| uv_cmp | input | 1 | Cell below under-voltage threshold |
| depl_cmp | input | 1 | Cell below severe-depletion threshold |
| oc_cmp | input | 1 | Switch drop above over-current threshold |
| pack_ok | input | 1 | Pack terminal has recovered |
| chg_det | input | 1 | Charger detected on the pack terminal |
| ot_cmp | input | 1 | Device above temperature limit |
| wake_n | input | 1 | Wake pin, active low |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 fault byte, 1 feature byte |
| wr_data | input | 8 | Host write data |
| chg_en | output | 1 | Charge switch enable |
| dchg_en | output | 1 | Discharge switch enable |
| test_en | output | 1 | Load-test current enable |
| rcv_en | output | 1 | Recovery-charge path enable |
| awake | output | 1 | 1 in active mode |
| status_prot | output | 8 | Flags, live enables and permissions |
| status_feat | output | 8 | Wake flag (bit 7) and OT flag (bit 0) |

## Verification
Most internal state reaches the ports with at most one edge of delay. A stuck or mis-set fault latch shows on `chg_en` or `dchg_en` in the cycle after the edge that should have changed it. A sticky flag that is lost or wrongly set appears in the status bytes at the same edge. A delay counter that is off by one moves the trip edge by one cycle, so the bench checks each counter one cycle short of its limit and at its limit. It also interrupts the over-voltage count once to check the restart. A wrong power-mode decision shows on `awake` and forces both enables off. The reference model compares every output on every clock, so a divergence is reported in the cycle it occurs.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;

   typedef enum logic {
      PWR_SLEEP  = 1'b0,
      PWR_ACTIVE = 1'b1
   } pwr_mode_t;

   localparam int unsigned NUM_QUAL = 4;
   localparam int unsigned Q_OV = 0;
   localparam int unsigned Q_UV = 1;
   localparam int unsigned Q_OC = 2;
   localparam int unsigned Q_SC = 3;

   // fault byte bit positions
   localparam int unsigned B_OV   = 7;
   localparam int unsigned B_UV   = 6;
   localparam int unsigned B_ZERO = 5;
   localparam int unsigned B_DOC  = 4;
   localparam int unsigned B_CHG  = 3;
   localparam int unsigned B_DCHG = 2;
   localparam int unsigned B_CE   = 1;
   localparam int unsigned B_DE   = 0;
   // feature byte bit positions
   localparam int unsigned B_PSF  = 7;
   localparam int unsigned B_OT   = 0;

   function automatic int unsigned pick_ticks(input int unsigned idx,
                                              input int unsigned t_ov,
                                              input int unsigned t_uv,
                                              input int unsigned t_oc,
                                              input int unsigned t_sc);
      case (idx)
         Q_OV:    return t_ov;
         Q_UV:    return t_uv;
         Q_OC:    return t_oc;
         default: return t_sc;
      endcase
   endfunction

endpackage

// File: rtl/bg_qual_timer.sv
module bg_qual_timer #(
   parameter int unsigned TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic cond,
   output logic fire
);

   if (TICKS < 1) begin : g_bad_ticks
      $error("bg_qual_timer: TICKS must be at least 1");
   end

   if (TICKS == 1) begin : g_direct
      assign fire = run & cond;
   end else begin : g_count
      localparam int unsigned CW = $clog2(TICKS);
      localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
      logic [CW-1:0] cnt;

      assign fire = run & cond & (cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (!run || !cond || fire) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/bg_flag_bank.sv
module bg_flag_bank
   import batt_guard_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_prot,
   input  logic          wr_feat,
   input  logic [DW-1:0] wr_data,
   input  logic          set_ov,
   input  logic          set_uv,
   input  logic          set_doc,
   input  logic          set_ot,
   input  logic          wake_evt,
   input  logic          ps_low,
   output logic          f_ov,
   output logic          f_uv,
   output logic          f_doc,
   output logic          f_ce,
   output logic          f_de,
   output logic          f_ot,
   output logic          f_psf
);

   if (DW < 8) begin : g_bad_width
      $error("bg_flag_bank: DW must be at least 8");
   end

   // host writes first, hardware events afterwards so they win
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_ov  <= 1'b0;
         f_uv  <= 1'b1;
         f_doc <= 1'b1;
         f_ce  <= 1'b1;
         f_de  <= 1'b1;
         f_ot  <= 1'b0;
         f_psf <= 1'b1;
      end else begin
         if (wr_prot) begin
            f_ov  <= wr_data[B_OV];
            f_uv  <= wr_data[B_UV];
            f_doc <= wr_data[B_DOC];
            f_ce  <= wr_data[B_CE];
            f_de  <= wr_data[B_DE];
         end
         if (wr_feat) begin
            f_psf <= wr_data[B_PSF];
            f_ot  <= wr_data[B_OT];
         end
         if (set_ov)  f_ov  <= 1'b1;
         if (set_uv)  f_uv  <= 1'b1;
         if (set_doc) f_doc <= 1'b1;
         if (set_ot)  f_ot  <= 1'b1;
         if (ps_low)  f_psf <= 1'b0;
         if (wake_evt) begin
            f_ce <= 1'b1;
            f_de <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/batt_guard.sv
module batt_guard
   import batt_guard_pkg::*;
#(
   parameter int unsigned OV_TICKS = 40,
   parameter int unsigned UV_TICKS = 24,
   parameter int unsigned OC_TICKS = 10,
   parameter int unsigned SC_TICKS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ov_cmp,
   input  logic       below_ce,
   input  logic       uv_cmp,
   input  logic       depl_cmp,
   input  logic       oc_cmp,
   input  logic       pack_ok,
   input  logic       chg_det,
   input  logic       ot_cmp,
   input  logic       wake_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   output logic       chg_en,
   output logic       dchg_en,
   output logic       test_en,
   output logic       rcv_en,
   output logic       awake,
   output logic [7:0] status_prot,
   output logic [7:0] status_feat
);

   localparam int unsigned DW = 8;

   if (OV_TICKS < 1 || UV_TICKS < 1 || OC_TICKS < 1 || SC_TICKS < 1) begin : g_bad_cfg
      $error("batt_guard: every delay must be at least one tick");
   end

   pwr_mode_t           mode;
   logic                active;
   logic [NUM_QUAL-1:0] qcond;
   logic [NUM_QUAL-1:0] qfire;
   logic                ov_trip, doc_trip, depl_seen;
   logic                wake_evt;
   logic                f_ov, f_uv, f_doc, f_ce, f_de, f_ot, f_psf;
   logic                ot_block;

   assign active = (mode == PWR_ACTIVE);

   always_comb begin
      qcond       = '0;
      qcond[Q_OV] = ov_cmp;
      qcond[Q_UV] = uv_cmp;
      qcond[Q_OC] = oc_cmp;
      qcond[Q_SC] = depl_cmp;
   end

   for (genvar gi = 0; gi < NUM_QUAL; gi++) begin : g_qual
      localparam int unsigned T = pick_ticks(gi, OV_TICKS, UV_TICKS, OC_TICKS, SC_TICKS);
      bg_qual_timer #(.TICKS(T)) u_tmr (
         .clk  (clk),
         .rst_n(rst_n),
         .run  (active),
         .cond (qcond[gi]),
         .fire (qfire[gi])
      );
   end

   assign wake_evt = !active && (!wake_n || chg_det) && !depl_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= PWR_SLEEP;
         ov_trip   <= 1'b0;
         doc_trip  <= 1'b0;
         depl_seen <= 1'b0;
      end else if (active) begin
         if (qfire[Q_OV])               ov_trip <= 1'b1;
         else if (below_ce || oc_cmp)   ov_trip <= 1'b0;

         if (qfire[Q_OC] || qfire[Q_SC]) begin
            doc_trip <= 1'b1;
            if (qfire[Q_SC]) depl_seen <= 1'b1;
         end else if (pack_ok) begin
            doc_trip  <= 1'b0;
            depl_seen <= 1'b0;
         end

         if (qfire[Q_UV]) mode <= PWR_SLEEP;
      end else if (wake_evt) begin
         mode    <= PWR_ACTIVE;
         ov_trip <= ov_cmp;
      end
   end

   bg_flag_bank #(.DW(DW)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_prot (wr_en && !wr_sel),
      .wr_feat (wr_en && wr_sel),
      .wr_data (wr_data),
      .set_ov  (qfire[Q_OV] || (wake_evt && ov_cmp)),
      .set_uv  (qfire[Q_UV]),
      .set_doc (qfire[Q_OC] || qfire[Q_SC]),
      .set_ot  (active && ot_cmp),
      .wake_evt(wake_evt),
      .ps_low  (!wake_n),
      .f_ov    (f_ov),
      .f_uv    (f_uv),
      .f_doc   (f_doc),
      .f_ce    (f_ce),
      .f_de    (f_de),
      .f_ot    (f_ot),
      .f_psf   (f_psf)
   );

   assign ot_block = f_ot || ot_cmp;
   assign chg_en   = active && f_ce && !ov_trip && !doc_trip && !ot_block;
   assign dchg_en  = active && f_de && !doc_trip && !ot_block;
   assign test_en  = active && doc_trip;
   assign rcv_en   = active && doc_trip && depl_seen && !depl_cmp;
   assign awake    = active;

   always_comb begin
      status_prot         = '0;
      status_prot[B_OV]   = f_ov;
      status_prot[B_UV]   = f_uv;
      status_prot[B_ZERO] = 1'b0;
      status_prot[B_DOC]  = f_doc;
      status_prot[B_CHG]  = chg_en;
      status_prot[B_DCHG] = dchg_en;
      status_prot[B_CE]   = f_ce;
      status_prot[B_DE]   = f_de;
      status_feat         = '0;
      status_feat[B_PSF]  = f_psf;
      status_feat[B_OT]   = f_ot;
   end

endmodule

// File: rtl/batt_guard_chk.sv
module batt_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       depl_cmp,
   input logic       ot_cmp,
   input logic       wake_n,
   input logic       wr_en,
   input logic       wr_sel,
   input logic       chg_en,
   input logic       dchg_en,
   input logic       test_en,
   input logic       rcv_en,
   input logic       awake,
   input logic [7:0] status_prot,
   input logic [7:0] status_feat
);

   AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !awake |-> (!chg_en && !dchg_en)); // R5

   AST_NO_WAKE_DEPL: assert property (@(posedge clk) disable iff (!rst_n)
      (!awake && depl_cmp) |=> !awake); // R2

   AST_WAKE_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(awake) |-> (status_prot[1:0] == 2'b11)); // R2

   AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ot_cmp |-> (!chg_en && !dchg_en)); // R8

   AST_RCV_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_en |-> test_en); // R7

   AST_UV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_prot[6] && !(wr_en && !wr_sel)) |=> status_prot[6]); // R11

   AST_PSF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_n |=> !status_feat[7]); // R11

   AST_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      !status_prot[5]); // R12

endmodule

bind batt_guard batt_guard_chk u_chk (.*);

// File: tb/batt_guard_test.sv
`timescale 1ns/1ps
module batt_guard_test;

   localparam int OVT = 40;
   localparam int UVT = 24;
   localparam int OCT = 10;
   localparam int SCT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ov_cmp = 0, below_ce = 0, uv_cmp = 0, depl_cmp = 0, oc_cmp = 0;
   logic pack_ok = 0, chg_det = 0, ot_cmp = 0, wake_n = 1;
   logic wr_en = 0, wr_sel = 0;
   logic [7:0] wr_data = 8'h00;
   logic chg_en, dchg_en, test_en, rcv_en, awake;
   logic [7:0] status_prot, status_feat;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   batt_guard #(.OV_TICKS(OVT), .UV_TICKS(UVT), .OC_TICKS(OCT), .SC_TICKS(SCT)) uut (
      .clk(clk), .rst_n(rst_n), .ov_cmp(ov_cmp), .below_ce(below_ce), .uv_cmp(uv_cmp),
      .depl_cmp(depl_cmp), .oc_cmp(oc_cmp), .pack_ok(pack_ok), .chg_det(chg_det),
      .ot_cmp(ot_cmp), .wake_n(wake_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .chg_en(chg_en), .dchg_en(dchg_en), .test_en(test_en), .rcv_en(rcv_en),
      .awake(awake), .status_prot(status_prot), .status_feat(status_feat)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit m_act, m_ov, m_uv, m_doc, m_ce, m_de, m_ot, m_psf, m_ovt, m_doct, m_dep;
   int m_cnt[4];
   int m_lim[4] = '{OVT, UVT, OCT, SCT};
   bit m_f[4];
   bit m_c[4];
   bit m_wk;
   bit e_chg, e_dchg;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_ov = 0; m_uv = 1; m_doc = 1; m_ce = 1; m_de = 1;
         m_ot = 0; m_psf = 1; m_ovt = 0; m_doct = 0; m_dep = 0;
         for (int i = 0; i < 4; i++) m_cnt[i] = 0;
      end else begin
         m_c = '{ov_cmp, uv_cmp, oc_cmp, depl_cmp};
         for (int i = 0; i < 4; i++) begin
            if (m_act && m_c[i]) begin
               m_cnt[i] = m_cnt[i] + 1;
               m_f[i] = (m_cnt[i] == m_lim[i]);
               if (m_f[i]) m_cnt[i] = 0;
            end else begin
               m_cnt[i] = 0;
               m_f[i] = 0;
            end
         end
         m_wk = !m_act && (!wake_n || chg_det) && !depl_cmp;
         if (wr_en && !wr_sel) begin
            m_ov = wr_data[7]; m_uv = wr_data[6]; m_doc = wr_data[4];
            m_ce = wr_data[1]; m_de = wr_data[0];
         end
         if (wr_en && wr_sel) begin
            m_psf = wr_data[7]; m_ot = wr_data[0];
         end
         if (m_f[0] || (m_wk && ov_cmp)) m_ov = 1;
         if (m_f[1]) m_uv = 1;
         if (m_f[2] || m_f[3]) m_doc = 1;
         if (m_act && ot_cmp) m_ot = 1;
         if (!wake_n) m_psf = 0;
         if (m_wk) begin m_ce = 1; m_de = 1; end
         if (m_act) begin
            if (m_f[0]) m_ovt = 1;
            else if (below_ce || oc_cmp) m_ovt = 0;
            if (m_f[2] || m_f[3]) begin
               m_doct = 1;
               if (m_f[3]) m_dep = 1;
            end else if (pack_ok) begin
               m_doct = 0; m_dep = 0;
            end
            if (m_f[1]) m_act = 0;
         end else if (m_wk) begin
            m_act = 1;
            m_ovt = ov_cmp;
         end
      end
      #2;
      if (rst_n && !done) begin
         e_chg  = m_act && m_ce && !m_ovt && !m_doct && !m_ot && !ot_cmp;
         e_dchg = m_act && m_de && !m_doct && !m_ot && !ot_cmp;
         chk("R3 chg_en", chg_en, e_chg);
         chk("R6 dchg_en", dchg_en, e_dchg);
         chk("R6 test_en", test_en, m_act && m_doct);
         chk("R7 rcv_en", rcv_en, m_act && m_doct && m_dep && !depl_cmp);
         chk("R5 awake", awake, m_act);
         chk("R12 status_prot", status_prot,
             {m_ov, m_uv, 1'b0, m_doc, e_chg, e_dchg, m_ce, m_de});
         chk("R11 status_feat", status_feat, {m_psf, 6'b0, m_ot});
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input bit sel, input logic [7:0] d);
      wr_en = 1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 0; wr_sel = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk("R1 status_prot", status_prot, 8'h53);
      chk("R1 status_feat", status_feat, 8'h80);
      chk("R1 awake", awake, 0);
      chk("R1 enables", {chg_en, dchg_en, test_en, rcv_en}, 0);

      // R2 no wake while depleted, then wake by charger
      chg_det = 1; depl_cmp = 1;
      cyc(2);
      chk("R2 stays asleep when depleted", awake, 0);
      depl_cmp = 0;
      cyc(1);
      chk("R2 wake by charger", awake, 1);
      chk("R2 outputs on", {chg_en, dchg_en}, 2'b11);
      chk("R12 layout after wake", status_prot, 8'h5F);
      chg_det = 0;

      host_write(0, 8'h03);
      chk("R11 host clears flags", status_prot, 8'h0F);

      // R3 over-voltage with restart
      ov_cmp = 1;
      cyc(OVT - 1);
      chk("R3 one short of delay", chg_en, 1);
      ov_cmp = 0;
      cyc(1);
      ov_cmp = 1;
      cyc(OVT - 1);
      chk("R3 count restarted", chg_en, 1);
      cyc(1);
      chk("R3 charge off", chg_en, 0);
      chk("R3 discharge stays", dchg_en, 1);
      chk("R3 flag and byte", status_prot, 8'h87);

      // R4 release paths
      ov_cmp = 0;
      cyc(2);
      chk("R4 still tripped", chg_en, 0);
      below_ce = 1;
      cyc(1);
      chk("R4 release by below_ce", chg_en, 1);
      below_ce = 0;
      chk("R11 ov flag sticky", status_prot[7], 1);
      ov_cmp = 1;
      cyc(OVT);
      chk("R4 retrip", chg_en, 0);
      ov_cmp = 0; oc_cmp = 1;
      cyc(1);
      oc_cmp = 0;
      chk("R4 release by discharge drop", chg_en, 1);

      // R9 permissions
      host_write(0, 8'h01);
      chk("R9 CE=0 charge off", {chg_en, dchg_en}, 2'b01);
      host_write(0, 8'h02);
      chk("R9 DE=0 discharge off", {chg_en, dchg_en}, 2'b10);
      host_write(0, 8'h03);

      // R6 over-current
      oc_cmp = 1;
      cyc(OCT - 1);
      chk("R6 one short of delay", dchg_en, 1);
      cyc(1);
      chk("R6 both off", {chg_en, dchg_en}, 2'b00);
      chk("R6 test current", test_en, 1);
      chk("R7 no recovery after over-current", rcv_en, 0);
      chk("R6 doc flag", status_prot[4], 1);
      oc_cmp = 0;
      cyc(3);
      chk("R6 held until pack recovers", {chg_en, dchg_en, test_en}, 3'b001);
      pack_ok = 1;
      cyc(1);
      chk("R6 released", {chg_en, dchg_en, test_en}, 3'b110);
      pack_ok = 0;

      // R6/R7 depletion
      depl_cmp = 1;
      cyc(SCT);
      chk("R6 depletion trip", {chg_en, dchg_en, test_en}, 3'b001);
      chk("R7 no recovery while depleted", rcv_en, 0);
      depl_cmp = 0;
      cyc(1);
      chk("R7 recovery enabled", rcv_en, 1);
      pack_ok = 1;
      cyc(1);
      chk("R7 recovery ends", rcv_en, 0);
      chk("R6 restore", {chg_en, dchg_en}, 2'b11);
      pack_ok = 0;

      // R8 over-temperature
      ot_cmp = 1;
      #1;
      chk("R8 immediate off", {chg_en, dchg_en}, 2'b00);
      cyc(1);
      chk("R8 OT flag", status_feat, 8'h81);
      ot_cmp = 0;
      cyc(2);
      chk("R8 held until host clears", {chg_en, dchg_en}, 2'b00);
      host_write(1, 8'h80);
      chk("R8 restored", {chg_en, dchg_en}, 2'b11);
      host_write(1, 8'h81);
      chk("R8 host forces off", {chg_en, dchg_en}, 2'b00);
      host_write(1, 8'h80);
      chk("R8 restored again", {chg_en, dchg_en}, 2'b11);

      // R11 wake flag
      wake_n = 0;
      cyc(1);
      chk("R11 wake flag cleared", status_feat[7], 0);
      wake_n = 1;
      cyc(3);
      chk("R11 wake flag stays clear", status_feat[7], 0);
      host_write(1, 8'h80);
      chk("R11 host sets wake flag", status_feat, 8'h80);

      // R5 under-voltage
      uv_cmp = 1;
      cyc(UVT - 1);
      chk("R5 one short of delay", awake, 1);
      cyc(1);
      chk("R5 sleep", awake, 0);
      chk("R5 outputs off", {chg_en, dchg_en}, 2'b00);
      chk("R5 uv flag", status_prot[6], 1);
      uv_cmp = 0;
      cyc(3);
      chk("R5 stays asleep", awake, 0);
      host_write(0, 8'h50);
      chk("R2 permissions cleared in sleep", status_prot[1:0], 0);

      // R10 zero over-voltage delay on wake
      ov_cmp = 1; chg_det = 1;
      cyc(1);
      chk("R2 awake again", awake, 1);
      chk("R2 permissions restored", status_prot[1:0], 2'b11);
      chk("R10 charge held off", {chg_en, dchg_en}, 2'b01);
      chk("R10 ov flag", status_prot[7], 1);
      chg_det = 0; ov_cmp = 0; below_ce = 1;
      cyc(1);
      chk("R10 release", chg_en, 1);
      below_ce = 0;
      cyc(2);
      finish_run();
   end

endmodule